// File: doc/BRIEF.md
# Microcoded Control Sequencer for a 16-bit Multicycle CPU

This block is the control unit of a small 16-bit multicycle processor. A 256-word by 32-bit control store, written as a synthesizable case table, holds one microprogram routine for each opcode. A 32-bit present-state register holds the microword that is active in the current cycle. Every field of that microword drives one datapath control output directly. Two fields choose the next microaddress: a dispatch flag and an 8-bit link.

Each instruction passes through two shared states. The first is a fetch state. The second is a decode state, which has the dispatch flag set. From decode the sequencer jumps to the routine of the opcode in the instruction register, and that routine runs for one to three cycles. The last word of each routine links back to fetch. Conditional branches write the PC only while the ALU equality flag is high.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, the sequencer is held in the fetch state, whatever `ir` holds. The outputs then show the fetch pattern, whose fields are listed in R2.
- R2: Fetch state: `pc_inc`=1, `ir_we`=1, `mem_re`=1, `addr_from_alu`=0, `mem_we`=0, and every other output is 0. The following cycle is always decode: `spc_we`=1, `reg_rd_sel`=2'b11, `alu_b_sel`=2'b01, and every other output is 0.
- R3: The opcode is `ir[15:12]`. From one fetch to the next, each opcode takes a fixed number of cycles: 0→2, 1→4, 2→4, 3→4, 4→5, 5→4, 6→3, 7→3, 0xA→4, 0xB→4, 0xC→4, 0xD→4.
- R4: Opcodes 0x8, 0x9, 0xE and 0xF behave like opcode 0. They take 2 cycles and assert no write strobe outside fetch and decode.
- R5: Opcode 6 (branch-if-equal) has one execute cycle. In that cycle `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_func`=4'h1 and `pc_sel_branch`=1, and `pc_we` equals `eq`.
- R6: Opcode 7 (jump) has one execute cycle. In that cycle `pc_we`=1, `pc_sel_branch`=0, and every other output is 0.
- R7: Opcode 4 (load) runs three cycles after decode. Cycle 1 computes the address: `alu_a_sel`=1, `alu_b_sel`=2'b01, `alu_func`=0. Cycle 2 holds those fields and adds `addr_from_alu`=1, `mem_re`=1 and `mdr_we`=1. Cycle 3 has only `reg_src_mdr`=1 and `reg_we_sel`=2'b01.
- R8: Opcode 5 (store) runs two cycles after decode. Cycle 1 is the same as load cycle 1. Cycle 2 holds the same ALU fields and adds `addr_from_alu`=1 and `mem_we`=1.
- R9: ALU encodings: `alu_b_sel` 00 = second register, 01 = sign-extended immediate, 10 = zero-extended immediate. `alu_func` 0 = add, 1 = subtract, 2 = AND, 3 = OR, 8 = shift left, 9 = shift right. In both cycles after decode, the ALU routines use `alu_a_sel`=1 with these (`alu_b_sel`, `alu_func`) pairs: op 1 (00,0), op 2 (10,8), op 3 (10,9), op 0xA (01,0), op 0xB (01,1), op 0xC (10,2), op 0xD (10,3).
- R10: In the second cycle after decode, the ALU routines of R9 keep their ALU fields and assert `reg_we_sel`=2'b01 with `reg_src_mdr`=0. Their first cycle writes nothing.
- R11: `ir` is sampled only at the end of decode. A change of `ir` during the execute cycles does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| eq | input | 1 | ALU equality flag |
| pc_inc | output | 1 | Increment PC |
| pc_we | output | 1 | PC write (unconditional, or conditional on `eq`) |
| pc_sel_branch | output | 1 | 1: PC loads branch target, 0: jump target |
| epc_we | output | 1 | Exception PC write |
| addr_from_alu | output | 1 | 1: ALU output addresses memory, 0: PC |
| mem_we | output | 1 | Memory write |
| mem_re | output | 1 | Memory read strobe |
| ir_we | output | 1 | Instruction register write |
| mdr_we | output | 1 | Memory data register write |
| spc_we | output | 1 | Saved-PC register write |
| alu_a_sel | output | 1 | ALU A source: 0 PC, 1 first register |
| alu_b_sel | output | 2 | ALU B source (R9 encoding; 11 = zero) |
| reg_src_mdr | output | 1 | Register write data: 0 ALU, 1 MDR |
| reg_rd_sel | output | 2 | Register read-port selection |
| reg_we_sel | output | 2 | Register write target (00 none, 01 first, 10 second, 11 both) |
| alu_func | output | 4 | ALU operation (R9 encoding) |

## Verification
Every output comes straight from the present-state register, so a wrong microword shows at the ports in the same cycle it is loaded. A wrong dispatch is visible one cycle after decode as an unexpected execute pattern. A wrong link shows up in the following cycle, either as a missing or early fetch pattern (`ir_we` high) or as a wrong routine, and so the cycle count between fetches also changes. A `pc_we` fault in the branch routine appears in that single execute cycle, and only when `eq` has the opposite value, which is why both values of `eq` are driven.

// File: rtl/useq_pkg.sv
// Package: shared microword layout and address map of the control sequencer.
// Assumes an 8-bit microaddress and a 4-bit opcode field.
package useq_pkg;
    localparam int UADDR_W = 8;
    localparam int UWORD_W = 32;
    localparam int OPC_W   = 4;
    localparam int DISP_STRIDE = 16;
    localparam int DISP_OFFS   = 2;

    typedef struct packed {
        logic                pc_inc;
        logic                pc_wr;
        logic                pc_wrcond;
        logic                pc_src;
        logic                epc_wr;
        logic                iord;
        logic                mem_wr;
        logic                mem_rd;
        logic                ir_wr;
        logic                mdr_wr;
        logic                spc_wr;
        logic                alu_a;
        logic [1:0]          alu_b;
        logic                reg_src;
        logic [1:0]          reg_rd;
        logic [1:0]          reg_wr;
        logic [3:0]          funct;
        logic                branch;
        logic [UADDR_W-1:0]  link;
    } uword_t;

    // Entry address of the routine for a given opcode
    function automatic logic [UADDR_W-1:0] disp_addr(input int op);
        return UADDR_W'(DISP_STRIDE * op + DISP_OFFS);
    endfunction

    localparam logic [UADDR_W-1:0] A_FETCH  = '0;
    localparam logic [UADDR_W-1:0] A_DECODE = UADDR_W'(1);
    localparam logic [UADDR_W-1:0] A_RFMT   = disp_addr(1);
    localparam logic [UADDR_W-1:0] A_SLL    = disp_addr(2);
    localparam logic [UADDR_W-1:0] A_SRL    = disp_addr(3);
    localparam logic [UADDR_W-1:0] A_LOAD   = disp_addr(4);
    localparam logic [UADDR_W-1:0] A_STORE  = disp_addr(5);
    localparam logic [UADDR_W-1:0] A_BEQ    = disp_addr(6);
    localparam logic [UADDR_W-1:0] A_JMP    = disp_addr(7);
    localparam logic [UADDR_W-1:0] A_ADDI   = disp_addr(10);
    localparam logic [UADDR_W-1:0] A_SUBI   = disp_addr(11);
    localparam logic [UADDR_W-1:0] A_ANDI   = disp_addr(12);
    localparam logic [UADDR_W-1:0] A_ORI    = disp_addr(13);
endpackage

// File: rtl/useq_rom.sv
// Control store: combinational read of one microword per address.
// Assumes unlisted addresses hold an all-zero word that links to fetch.
module useq_rom
    import useq_pkg::*;
(
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);
    // Two-cycle ALU routine: operand/function setup, then write-back
    function automatic uword_t alu_step(input logic [1:0] bsel, input logic [3:0] fn,
                                        input logic wb, input logic [UADDR_W-1:0] nxt);
        uword_t w;
        w        = '0;
        w.alu_a  = 1'b1;
        w.alu_b  = bsel;
        w.funct  = fn;
        w.reg_wr = wb ? 2'b01 : 2'b00;
        w.link   = nxt;
        return w;
    endfunction

    // Microprogram table
    always_comb begin
        word = '0;
        case (addr)
            A_FETCH: begin
                word.pc_inc = 1'b1;
                word.ir_wr  = 1'b1;
                word.mem_rd = 1'b1;
                word.link   = A_DECODE;
            end
            A_DECODE: begin
                word.spc_wr = 1'b1;
                word.reg_rd = 2'b11;
                word.alu_b  = 2'b01;
                word.branch = 1'b1;
            end
            A_RFMT:      word = alu_step(2'b00, 4'h0, 1'b0, A_RFMT + 1'b1);
            A_RFMT + 1:  word = alu_step(2'b00, 4'h0, 1'b1, A_FETCH);
            A_SLL:       word = alu_step(2'b10, 4'h8, 1'b0, A_SLL + 1'b1);
            A_SLL + 1:   word = alu_step(2'b10, 4'h8, 1'b1, A_FETCH);
            A_SRL:       word = alu_step(2'b10, 4'h9, 1'b0, A_SRL + 1'b1);
            A_SRL + 1:   word = alu_step(2'b10, 4'h9, 1'b1, A_FETCH);
            A_LOAD:      word = alu_step(2'b01, 4'h0, 1'b0, A_LOAD + 1'b1);
            A_LOAD + 1: begin
                word        = alu_step(2'b01, 4'h0, 1'b0, A_LOAD + 2'd2);
                word.iord   = 1'b1;
                word.mem_rd = 1'b1;
                word.mdr_wr = 1'b1;
            end
            A_LOAD + 2: begin
                word.reg_src = 1'b1;
                word.reg_wr  = 2'b01;
            end
            A_STORE:     word = alu_step(2'b01, 4'h0, 1'b0, A_STORE + 1'b1);
            A_STORE + 1: begin
                word        = alu_step(2'b01, 4'h0, 1'b0, A_FETCH);
                word.iord   = 1'b1;
                word.mem_wr = 1'b1;
            end
            A_BEQ: begin
                word           = alu_step(2'b00, 4'h1, 1'b0, A_FETCH);
                word.pc_wrcond = 1'b1;
                word.pc_src    = 1'b1;
            end
            A_JMP:       word.pc_wr = 1'b1;
            A_ADDI:      word = alu_step(2'b01, 4'h0, 1'b0, A_ADDI + 1'b1);
            A_ADDI + 1:  word = alu_step(2'b01, 4'h0, 1'b1, A_FETCH);
            A_SUBI:      word = alu_step(2'b01, 4'h1, 1'b0, A_SUBI + 1'b1);
            A_SUBI + 1:  word = alu_step(2'b01, 4'h1, 1'b1, A_FETCH);
            A_ANDI:      word = alu_step(2'b10, 4'h2, 1'b0, A_ANDI + 1'b1);
            A_ANDI + 1:  word = alu_step(2'b10, 4'h2, 1'b1, A_FETCH);
            A_ORI:       word = alu_step(2'b10, 4'h3, 1'b0, A_ORI + 1'b1);
            A_ORI + 1:   word = alu_step(2'b10, 4'h3, 1'b1, A_FETCH);
            default:     word = '0;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
// Next-address selector: dispatch on opcode or follow the microword link.
// Assumes opcodes without a routine map to fetch.
module useq_next
    import useq_pkg::*;
(
    input  logic               branch,
    input  logic [UADDR_W-1:0] link,
    input  logic [OPC_W-1:0]   opcode,
    output logic [UADDR_W-1:0] next_addr
);
    logic [UADDR_W-1:0] disp;

    // Opcode dispatch table
    always_comb begin
        case (opcode)
            4'h0, 4'h8, 4'h9, 4'hE, 4'hF: disp = A_FETCH;
            default:                      disp = disp_addr(int'(opcode));
        endcase
    end

    // Choose dispatch target or sequential link
    always_comb next_addr = branch ? disp : link;
endmodule

// File: rtl/useq_ctrl.sv
// Top of the microcoded sequencer: 32-bit present-state register loaded
// from the control store each cycle; outputs decode the held microword.
// Assumes ir is stable at the end of the decode cycle.
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int IR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IR_W-1:0] ir,
    input  logic            eq,
    output logic            pc_inc,
    output logic            pc_we,
    output logic            pc_sel_branch,
    output logic            epc_we,
    output logic            addr_from_alu,
    output logic            mem_we,
    output logic            mem_re,
    output logic            ir_we,
    output logic            mdr_we,
    output logic            spc_we,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            reg_src_mdr,
    output logic [1:0]      reg_rd_sel,
    output logic [1:0]      reg_we_sel,
    output logic [3:0]      alu_func
);
    localparam int OPC_LSB = IR_W - OPC_W;

    uword_t             cur_q;
    uword_t             rom_word;
    logic [UADDR_W-1:0] nxt_addr;
    logic [UADDR_W-1:0] rd_addr;

    useq_next u_next (
        .branch    (cur_q.branch),
        .link      (cur_q.link),
        .opcode    (ir[IR_W-1:OPC_LSB]),
        .next_addr (nxt_addr)
    );

    // Reset reads the fetch word, otherwise the selected successor
    always_comb rd_addr = rst_n ? nxt_addr : A_FETCH;

    useq_rom u_rom (
        .addr (rd_addr),
        .word (rom_word)
    );

    // Present-state register
    always_ff @(posedge clk) begin
        cur_q <= rom_word;
    end

    // Control outputs from the held microword
    always_comb begin
        pc_inc        = cur_q.pc_inc;
        pc_we         = cur_q.pc_wr | (cur_q.pc_wrcond & eq);
        pc_sel_branch = cur_q.pc_src;
        epc_we        = cur_q.epc_wr;
        addr_from_alu = cur_q.iord;
        mem_we        = cur_q.mem_wr;
        mem_re        = cur_q.mem_rd;
        ir_we         = cur_q.ir_wr;
        mdr_we        = cur_q.mdr_wr;
        spc_we        = cur_q.spc_wr;
        alu_a_sel     = cur_q.alu_a;
        alu_b_sel     = cur_q.alu_b;
        reg_src_mdr   = cur_q.reg_src;
        reg_rd_sel    = cur_q.reg_rd;
        reg_we_sel    = cur_q.reg_wr;
        alu_func      = cur_q.funct;
    end
endmodule

// File: rtl/useq_ctrl_chk.sv
// Checker for useq_ctrl: temporal rules across the control outputs.
module useq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eq,
    input logic       pc_inc,
    input logic       pc_we,
    input logic       pc_sel_branch,
    input logic       addr_from_alu,
    input logic       mem_we,
    input logic       mem_re,
    input logic       ir_we,
    input logic       mdr_we,
    input logic       spc_we,
    input logic       reg_src_mdr,
    input logic [1:0] reg_we_sel
);
    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        !rst_n |=> (ir_we && pc_inc && mem_re)); // R1
    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (spc_we && !ir_we)); // R2
    AST_FETCH_READS_BY_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |-> (!addr_from_alu && !mem_we)); // R2
    AST_BRANCH_NEEDS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel_branch) |-> eq); // R5
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        mdr_we |=> (reg_src_mdr && reg_we_sel == 2'b01)); // R7
    AST_STORE_ALU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (addr_from_alu && !mem_re)); // R8
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eq            (eq),
    .pc_inc        (pc_inc),
    .pc_we         (pc_we),
    .pc_sel_branch (pc_sel_branch),
    .addr_from_alu (addr_from_alu),
    .mem_we        (mem_we),
    .mem_re        (mem_re),
    .ir_we         (ir_we),
    .mdr_we        (mdr_we),
    .spc_we        (spc_we),
    .reg_src_mdr   (reg_src_mdr),
    .reg_we_sel    (reg_we_sel)
);

// File: tb/useq_ctrl_tb.sv
// Scoreboard bench: driver queues expected per-cycle control vectors,
// monitor compares them at each falling edge.
module useq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ir;
    logic        eq;
    logic pc_inc, pc_we, pc_sel_branch, epc_we, addr_from_alu, mem_we, mem_re;
    logic ir_we, mdr_we, spc_we, alu_a_sel, reg_src_mdr;
    logic [1:0] alu_b_sel, reg_rd_sel, reg_we_sel;
    logic [3:0] alu_func;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    useq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ir(ir), .eq(eq),
        .pc_inc(pc_inc), .pc_we(pc_we), .pc_sel_branch(pc_sel_branch),
        .epc_we(epc_we), .addr_from_alu(addr_from_alu), .mem_we(mem_we),
        .mem_re(mem_re), .ir_we(ir_we), .mdr_we(mdr_we), .spc_we(spc_we),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .reg_src_mdr(reg_src_mdr),
        .reg_rd_sel(reg_rd_sel), .reg_we_sel(reg_we_sel), .alu_func(alu_func)
    );

    function automatic logic [21:0] cv(
        input logic inc, pcw, psrc, epc, iord, memw, memr, irw, mdrw, spcw, alua,
        input logic [1:0] alub, input logic rsrc, input logic [1:0] rrd, rwr,
        input logic [3:0] fn);
        return {inc, pcw, psrc, epc, iord, memw, memr, irw, mdrw, spcw, alua,
                alub, rsrc, rrd, rwr, fn};
    endfunction

    function automatic logic [21:0] obs_vec();
        return {pc_inc, pc_we, pc_sel_branch, epc_we, addr_from_alu, mem_we, mem_re,
                ir_we, mdr_we, spc_we, alu_a_sel, alu_b_sel, reg_src_mdr,
                reg_rd_sel, reg_we_sel, alu_func};
    endfunction

    localparam logic [21:0] FETCH_V =
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
         2'b00, 1'b0, 2'b00, 2'b00, 4'h0};
    localparam logic [21:0] DECODE_V =
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
         2'b01, 1'b0, 2'b11, 2'b00, 4'h0};

    function automatic logic [21:0] alu_v(input logic [1:0] b, input logic [3:0] fn,
                                          input logic wb);
        return cv(0,0,0,0,0,0,0,0,0,0,1, b, 0, 2'b00, wb ? 2'b01 : 2'b00, fn);
    endfunction

    // Expected execute-cycle vector k (0-based after decode), from R5..R10
    function automatic logic [21:0] exp_exec(input logic [3:0] op, input int k,
                                             input logic eqv);
        case (op)
            4'h1: return alu_v(2'b00, 4'h0, k == 1);
            4'h2: return alu_v(2'b10, 4'h8, k == 1);
            4'h3: return alu_v(2'b10, 4'h9, k == 1);
            4'h4: begin
                if (k == 0) return alu_v(2'b01, 4'h0, 1'b0);
                if (k == 1) return cv(0,0,0,0,1,0,1,0,1,0,1, 2'b01, 0, 2'b00, 2'b00, 4'h0);
                return cv(0,0,0,0,0,0,0,0,0,0,0, 2'b00, 1, 2'b00, 2'b01, 4'h0);
            end
            4'h5: begin
                if (k == 0) return alu_v(2'b01, 4'h0, 1'b0);
                return cv(0,0,0,0,1,1,0,0,0,0,1, 2'b01, 0, 2'b00, 2'b00, 4'h0);
            end
            4'h6: return cv(0,eqv,1,0,0,0,0,0,0,0,1, 2'b00, 0, 2'b00, 2'b00, 4'h1);
            4'h7: return cv(0,1,0,0,0,0,0,0,0,0,0, 2'b00, 0, 2'b00, 2'b00, 4'h0);
            4'hA: return alu_v(2'b01, 4'h0, k == 1);
            4'hB: return alu_v(2'b01, 4'h1, k == 1);
            4'hC: return alu_v(2'b10, 4'h2, k == 1);
            4'hD: return alu_v(2'b10, 4'h3, k == 1);
            default: return '0;
        endcase
    endfunction

    // Cycle count per opcode (R3, R4)
    function automatic int op_len(input logic [3:0] op);
        case (op)
            4'h1, 4'h2, 4'h3, 4'h5, 4'hA, 4'hB, 4'hC, 4'hD: return 4;
            4'h4:       return 5;
            4'h6, 4'h7: return 3;
            default:    return 2;
        endcase
    endfunction

    typedef struct {
        logic [21:0] v;
        string       tag;
        int          prev_len;
    } exp_t;
    exp_t exp_q[$];
    int   cyc_since_fetch = 0;
    int   last_len = 0;

    // Monitor: pop one expected vector per cycle and compare
    always @(negedge clk) begin
        exp_t e;
        logic [21:0] o;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            o = obs_vec();
            checks++;
            if (o !== e.v) begin
                errors++;
                $display("FAIL %s: got %h expected %h", e.tag, o, e.v);
            end
            if (e.prev_len > 0) begin
                checks++;
                if (cyc_since_fetch != e.prev_len) begin
                    errors++;
                    $display("FAIL R3 cycle count: got %0d expected %0d",
                             cyc_since_fetch, e.prev_len);
                end
            end
        end
        if (ir_we) cyc_since_fetch = 1;
        else       cyc_since_fetch++;
    end

    // Driver: queue expectations for one instruction and feed its opcode
    task automatic run_op(input logic [3:0] op, input logic eqv, input bit scramble,
                          input string tag);
        exp_t e;
        int   n;
        n = op_len(op);
        e.v = FETCH_V;  e.tag = "R2 fetch";  e.prev_len = last_len;
        exp_q.push_back(e);
        e.v = DECODE_V; e.tag = "R2 decode"; e.prev_len = 0;
        exp_q.push_back(e);
        for (int k = 0; k < n - 2; k++) begin
            e.v = exp_exec(op, k, eqv);
            e.tag = tag;
            exp_q.push_back(e);
        end
        last_len = n;
        eq = eqv;
        @(negedge clk);
        #1 ir = {op, 12'h5A3};
        @(posedge clk);
        @(posedge clk);
        #1;
        if (scramble) ir = {4'h7, 12'h000};
        repeat (n - 2) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        ir    = 16'h0000;
        eq    = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (obs_vec() !== FETCH_V) begin
            errors++;
            $display("FAIL R1 reset: got %h expected %h", obs_vec(), FETCH_V);
        end
        ir = 16'h4000;  // R1: opcode present during reset must be ignored
        @(negedge clk);
        checks++;
        if (obs_vec() !== FETCH_V) begin
            errors++;
            $display("FAIL R1 reset with ir: got %h expected %h", obs_vec(), FETCH_V);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        run_op(4'h0, 1'b0, 1'b0, "R3 nop");
        run_op(4'h1, 1'b0, 1'b0, "R9 R10 rfmt");
        run_op(4'h2, 1'b0, 1'b0, "R9 R10 sll");
        run_op(4'h3, 1'b0, 1'b0, "R9 R10 srl");
        run_op(4'h4, 1'b0, 1'b0, "R7 load");
        run_op(4'h5, 1'b0, 1'b0, "R8 store");
        run_op(4'h6, 1'b1, 1'b0, "R5 beq taken");
        run_op(4'h6, 1'b0, 1'b0, "R5 beq not taken");
        run_op(4'h7, 1'b0, 1'b0, "R6 jump");
        run_op(4'hA, 1'b0, 1'b0, "R9 R10 addi");
        run_op(4'hB, 1'b1, 1'b0, "R9 R10 subi");
        run_op(4'hC, 1'b0, 1'b0, "R9 R10 andi");
        run_op(4'hD, 1'b0, 1'b0, "R9 R10 ori");
        run_op(4'h8, 1'b0, 1'b0, "R4 op8");
        run_op(4'h9, 1'b1, 1'b0, "R4 op9");
        run_op(4'hE, 1'b0, 1'b0, "R4 opE");
        run_op(4'hF, 1'b0, 1'b0, "R4 opF");
        run_op(4'h4, 1'b0, 1'b1, "R11 load with ir changed");
        run_op(4'hA, 1'b1, 1'b1, "R11 addi with ir changed");
        run_op(4'h0, 1'b0, 1'b0, "R3 nop");
        run_op(4'h0, 1'b0, 1'b0, "R3 nop");
        wait (exp_q.size() == 0);
        @(negedge clk);
        #1 finish_run();
    end
endmodule